// File: doc/BRIEF.md
# Dual Halfword Multiply-Subtract Accumulator

This datapath unit treats each of two 32-bit operands as a pair of signed 16-bit halfwords. It forms two signed 16x16 products and takes the upper-lane product away from the lower-lane product. It then adds an accumulator to that difference. An exchange control swaps the two halfwords of the second operand before the multiplications, which turns straight pairing into cross pairing. A mode control picks one of two accumulate paths. The short path adds a 32-bit accumulator and returns a 32-bit word. The long path adds a 64-bit accumulator, supplied as a high word and a low word, and returns a 64-bit result as a high word and a low word.

The unit captures one operation in every cycle in which `in_valid` is high. The result appears on the next clock edge with `out_valid` high, so one operation per cycle can be issued back to back. Between captures the result words keep their last value. Reset is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `dual_hmsa`

## Requirements
- R1: Each operand is split into a bottom halfword (bits 15:0) and a top halfword (bits 31:16), both signed. With `in_exch` low, the lower-lane product is A.bottom × B.bottom and the upper-lane product is A.top × B.top.
- R2: With `in_exch` high, the halfwords of B are swapped first. The lower-lane product becomes A.bottom × B.top and the upper-lane product becomes A.top × B.bottom.
- R3: The difference is the lower-lane product minus the upper-lane product, never the reverse.
- R4: With `in_long` low (short mode), `out_lo` = (difference + signed `in_acc_lo`) mod 2^32, with no saturation, and `out_hi` is zero. `in_acc_hi` has no effect.
- R5: With `in_long` high (long mode), the difference is sign-extended to 64 bits and added to {`in_acc_hi`,`in_acc_lo`} modulo 2^64. The sum is returned as {`out_hi`,`out_lo`}.
- R6: An operation presented with `in_valid` high appears on the outputs with `out_valid` high exactly one clock edge later. A cycle without `in_valid` gives `out_valid` low on the next edge.
- R7: While `rst_n` is low, `out_valid`, `out_hi` and `out_lo` are zero, and they clear as soon as `rst_n` falls. Release takes effect after two clock edges.
- R8: When no operation is captured, `out_hi` and `out_lo` hold their previous values whatever the other inputs do.
- R9: Operands with every halfword at -32768 give exactly 2^30 per product. This holds for both exchange settings and both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| in_valid | input | 1 | Capture the operation on this edge |
| in_exch | input | 1 | Swap the halfwords of B before multiplying |
| in_long | input | 1 | 1 = 64-bit accumulate path, 0 = 32-bit path |
| in_opa | input | 32 | Operand A, two signed halfwords |
| in_opb | input | 32 | Operand B, two signed halfwords |
| in_acc_hi | input | 32 | Accumulator high word (long mode only) |
| in_acc_lo | input | 32 | Accumulator low word, or the 32-bit accumulator in short mode |
| out_valid | output | 1 | Result words carry a fresh result |
| out_hi | output | 32 | Result high word (zero in short mode) |
| out_lo | output | 32 | Result low word |

## Verification
On every cycle the assertions check the one-edge valid latency, the holding of the result words between captures, and the zero high word in short mode. They also compare both accumulate paths against a 64-bit signed model built from the ports. Only the bench scenarios can show the clearing of the outputs when reset falls in the middle of an operation, and the delayed release. The same holds for the directed halfword corners: the -32768 pairs under both exchange settings, the subtraction order, and wrap-around of the 32-bit and 64-bit sums. These are mixed with back-to-back and gapped random traffic that is checked against a bench function.

// File: rtl/dhms_pkg.sv
package dhms_pkg;

  localparam int unsigned DHMS_LANES = 2;

  typedef enum logic {
    ACC_SHORT = 1'b0,
    ACC_LONG  = 1'b1
  } dhms_acc_mode_e;

endpackage

// File: rtl/dhms_rst_sync.sv
module dhms_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dhms_lane_mul.sv
module dhms_lane_mul
  import dhms_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]            opa,
  input  logic [WORD_W-1:0]            opb,
  input  logic                         exch,
  output logic [DHMS_LANES*PROD_W-1:0] prod_flat
);

  // Lane 0 is the bottom lane, lane 1 the top lane.
  for (genvar g = 0; g < DHMS_LANES; g++) begin : g_lane
    logic signed [HALF_W-1:0] a_h;
    logic signed [HALF_W-1:0] b_h;
    logic signed [PROD_W-1:0] a_x;
    logic signed [PROD_W-1:0] b_x;
    logic signed [PROD_W-1:0] p;

    assign a_h = opa[g*HALF_W +: HALF_W];
    assign b_h = exch ? opb[(DHMS_LANES-1-g)*HALF_W +: HALF_W]
                      : opb[g*HALF_W +: HALF_W];
    assign a_x = PROD_W'(a_h);
    assign b_x = PROD_W'(b_h);
    assign p   = a_x * b_x;
    assign prod_flat[g*PROD_W +: PROD_W] = p;
  end

endmodule

// File: rtl/dhms_acc_add.sv
module dhms_acc_add
  import dhms_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned DIFF_W = PROD_W + 1,
  localparam int unsigned LONG_W = 2 * WORD_W
) (
  input  logic [DHMS_LANES*PROD_W-1:0] prod_flat,
  input  dhms_acc_mode_e               mode,
  input  logic [WORD_W-1:0]            acc_hi,
  input  logic [WORD_W-1:0]            acc_lo,
  output logic [WORD_W-1:0]            res_hi,
  output logic [WORD_W-1:0]            res_lo
);

  logic [PROD_W-1:0] p_bot;
  logic [PROD_W-1:0] p_top;
  logic [DIFF_W-1:0] diff;
  logic [LONG_W-1:0] diff_ext;
  logic [LONG_W-1:0] sum_long;
  logic [WORD_W-1:0] sum_short;

  assign p_bot = prod_flat[0 +: PROD_W];
  assign p_top = prod_flat[PROD_W +: PROD_W];

  // Sign-extend each product by one bit so the difference cannot overflow.
  assign diff     = {p_bot[PROD_W-1], p_bot} - {p_top[PROD_W-1], p_top};
  assign diff_ext = {{(LONG_W-DIFF_W){diff[DIFF_W-1]}}, diff};

  assign sum_long  = diff_ext + {acc_hi, acc_lo};
  assign sum_short = diff[WORD_W-1:0] + acc_lo;

  always_comb begin
    unique case (mode)
      ACC_LONG: begin
        res_hi = sum_long[LONG_W-1:WORD_W];
        res_lo = sum_long[WORD_W-1:0];
      end
      default: begin
        res_hi = '0;
        res_lo = sum_short;
      end
    endcase
  end

endmodule

// File: rtl/dual_hmsa.sv
module dual_hmsa
  import dhms_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = 2 * HALF_W,
  localparam int unsigned PROD_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_exch,
  input  logic              in_long,
  input  logic [WORD_W-1:0] in_opa,
  input  logic [WORD_W-1:0] in_opb,
  input  logic [WORD_W-1:0] in_acc_hi,
  input  logic [WORD_W-1:0] in_acc_lo,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_hi,
  output logic [WORD_W-1:0] out_lo
);

  logic                         rst_sync_n;
  logic [DHMS_LANES*PROD_W-1:0] prod_flat;
  dhms_acc_mode_e               mode;
  logic [WORD_W-1:0]            res_hi;
  logic [WORD_W-1:0]            res_lo;

  logic              vld_q;
  logic              vld_d;
  logic [WORD_W-1:0] hi_q;
  logic [WORD_W-1:0] hi_d;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] lo_d;

  dhms_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dhms_lane_mul #(
    .HALF_W (HALF_W)
  ) u_mul (
    .opa       (in_opa),
    .opb       (in_opb),
    .exch      (in_exch),
    .prod_flat (prod_flat)
  );

  assign mode = in_long ? ACC_LONG : ACC_SHORT;

  dhms_acc_add #(
    .HALF_W (HALF_W)
  ) u_acc (
    .prod_flat (prod_flat),
    .mode      (mode),
    .acc_hi    (in_acc_hi),
    .acc_lo    (in_acc_lo),
    .res_hi    (res_hi),
    .res_lo    (res_lo)
  );

  // Next state: result words load only on a capture.
  always_comb begin
    vld_d = in_valid;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (in_valid) begin
      hi_d = res_hi;
      lo_d = res_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      vld_q <= vld_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign out_valid = vld_q;
  assign out_hi    = hi_q;
  assign out_lo    = lo_q;

endmodule

// File: rtl/dhms_chk.sv
module dhms_chk #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned LONG_W = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_exch,
  input logic              in_long,
  input logic [WORD_W-1:0] in_opa,
  input logic [WORD_W-1:0] in_opb,
  input logic [WORD_W-1:0] in_acc_hi,
  input logic [WORD_W-1:0] in_acc_lo,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_hi,
  input logic [WORD_W-1:0] out_lo
);

  logic signed [HALF_W-1:0] a_b, a_t, b_b, b_t;
  logic signed [LONG_W-1:0] m_long;
  logic signed [WORD_W-1:0] m_short;

  assign a_b = in_opa[HALF_W-1:0];
  assign a_t = in_opa[WORD_W-1:HALF_W];
  assign b_b = in_exch ? in_opb[WORD_W-1:HALF_W] : in_opb[HALF_W-1:0];
  assign b_t = in_exch ? in_opb[HALF_W-1:0] : in_opb[WORD_W-1:HALF_W];

  assign m_long = LONG_W'(a_b) * LONG_W'(b_b) - LONG_W'(a_t) * LONG_W'(b_t)
                + signed'({in_acc_hi, in_acc_lo});
  assign m_short = WORD_W'(a_b) * WORD_W'(b_b) - WORD_W'(a_t) * WORD_W'(b_t)
                 + signed'(in_acc_lo);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R6

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_hi) && $stable(out_lo))); // R8

  AST_SHORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_long) |=> (out_hi == '0)); // R4

  AST_SHORT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_long) |=> (out_lo == $past(m_short))); // R4

  AST_LONG_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_long) |=> ({out_hi, out_lo} == $past(m_long))); // R5

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEARS: assert (!out_valid && out_hi == '0 && out_lo == '0); // R7
    end
  end

endmodule

bind dual_hmsa dhms_chk #(
  .HALF_W (HALF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_exch   (in_exch),
  .in_long   (in_long),
  .in_opa    (in_opa),
  .in_opb    (in_opb),
  .in_acc_hi (in_acc_hi),
  .in_acc_lo (in_acc_lo),
  .out_valid (out_valid),
  .out_hi    (out_hi),
  .out_lo    (out_lo)
);

// File: tb/sim_dual_hmsa.sv
`timescale 1ns/1ps
module sim_dual_hmsa;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_exch;
  logic        in_long;
  logic [31:0] in_opa;
  logic [31:0] in_opb;
  logic [31:0] in_acc_hi;
  logic [31:0] in_acc_lo;
  logic        out_valid;
  logic [31:0] out_hi;
  logic [31:0] out_lo;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  bit          exp_v = 1'b0;
  logic [63:0] exp_res = '0;
  logic [63:0] held_res = '0;
  string       exp_tag = "R6";

  dual_hmsa u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_exch   (in_exch),
    .in_long   (in_long),
    .in_opa    (in_opa),
    .in_opb    (in_opb),
    .in_acc_hi (in_acc_hi),
    .in_acc_lo (in_acc_lo),
    .out_valid (out_valid),
    .out_hi    (out_hi),
    .out_lo    (out_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] hi, input logic [31:0] lo,
                                        input bit x, input bit l);
    longint ab = longint'($signed(a[15:0]));
    longint at = longint'($signed(a[31:16]));
    longint bb = longint'($signed(x ? b[31:16] : b[15:0]));
    longint bt = longint'($signed(x ? b[15:0] : b[31:16]));
    longint d  = ab * bb - at * bt;
    logic [63:0] s64;
    logic [31:0] s32;
    s64 = 64'(d) + {hi, lo};
    s32 = 32'(d) + lo;
    return l ? s64 : {32'h0, s32};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_pending();
    if (exp_v) begin
      chk(out_valid == 1'b1, "R6", "out_valid after capture", 64'(out_valid), 64'd1);
      chk({out_hi, out_lo} == exp_res, exp_tag, "result", {out_hi, out_lo}, exp_res);
    end else begin
      chk(out_valid == 1'b0, "R6", "out_valid idle", 64'(out_valid), 64'd0);
      chk({out_hi, out_lo} == held_res, "R8", "held result", {out_hi, out_lo}, held_res);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] hi, input logic [31:0] lo,
                      input bit x, input bit l, input string tag);
    @(negedge clk);
    check_pending();
    in_valid  = v;
    in_opa    = a;
    in_opb    = b;
    in_acc_hi = hi;
    in_acc_lo = lo;
    in_exch   = x;
    in_long   = l;
    exp_v     = v;
    if (v) begin
      exp_res  = model(a, b, hi, lo, x, l);
      held_res = exp_res;
      exp_tag  = tag;
    end
  endtask

  function automatic logic [15:0] pick_half();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b1; in_valid = 1'b0; in_exch = 1'b0; in_long = 1'b0;
    in_opa = '0; in_opb = '0; in_acc_hi = '0; in_acc_lo = '0;
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_hi == '0 && out_lo == '0, "R7", "in reset",
        {31'h0, out_valid, out_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_hi == '0 && out_lo == '0, "R7", "after release",
        {31'h0, out_valid, out_lo}, 64'd0);

    // R1 straight pairing: 2*7 - 3*5 = -1
    step(1, 32'h0003_0002, 32'h0005_0007, 32'hDEAD_BEEF, 32'h0, 0, 0, "R1");
    // R2 cross pairing: 2*5 - 3*7 = -11
    step(1, 32'h0003_0002, 32'h0005_0007, 32'h0, 32'h0, 1, 0, "R2");
    // R3 order: bottom 0, top 1 -> 0 - 1 = -1 (long, sign shows in high word)
    step(1, 32'h0001_0000, 32'h0001_0001, 32'h0, 32'h0, 0, 1, "R3");
    // R8 idle with changing inputs
    step(0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1, 32'h2, 1, 1, "R8");
    step(0, 32'hFFFF_FFFF, 32'h8000_8000, 32'h3, 32'h4, 0, 0, "R8");
    // R4 wrap of the 32-bit sum, acc_hi ignored
    step(1, 32'h0000_7FFF, 32'h0000_7FFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R4");
    step(1, 32'h8000_0000, 32'h7FFF_0000, 32'h0000_0001, 32'h8000_0000, 0, 0, "R4");
    // R5 sign extension of a negative difference and 64-bit wrap
    step(1, 32'h0001_0000, 32'h7FFF_0000, 32'h0, 32'h0, 0, 1, "R5");
    step(1, 32'h0000_7FFF, 32'h0000_7FFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R5");
    step(1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 0, 1, "R5");
    // R9 all -32768, every combination of exchange and mode
    for (int k = 0; k < 4; k++) begin
      step(1, 32'h8000_8000, 32'h8000_8000, 32'h0, 32'h0, k[0], k[1], "R9");
    end
    step(1, 32'h8000_8000, 32'h7FFF_8000, 32'h0, 32'h0, 0, 1, "R9");
    step(1, 32'h8000_8000, 32'h7FFF_8000, 32'h0, 32'h0, 1, 0, "R9");
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, "R8");

    // R7 reset falling mid-run clears outputs at once
    step(1, 32'h0003_0002, 32'h0005_0007, 32'h0, 32'h0000_0100, 0, 0, "R1");
    @(negedge clk);
    check_pending();
    in_valid = 1'b1;
    #2 rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0 && out_hi == '0 && out_lo == '0, "R7", "async clear",
        {31'h0, out_valid, out_lo}, 64'd0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R7", "still held one edge after release",
        64'(out_valid), 64'd0);
    repeat (4) @(negedge clk);
    exp_v = 1'b0;
    held_res = '0;

    // Random traffic, back to back and gapped
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 4) != 0;
      bit x = 1'($urandom);
      bit l = 1'($urandom);
      step(v, {pick_half(), pick_half()}, {pick_half(), pick_half()},
           $urandom, $urandom, x, l, l ? "R5" : "R4");
    end
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, "R8");
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule